// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is the boundary scan register for a device with `N_IN` input pins and `N_OUT` output pins. It sits in the pin path. Pad inputs flow through it to the core. Core output values flow through it to the output pads. Each pin has a cell with a shift stage, and each output cell also has an update latch. A TAP controller outside the block supplies the test clock, the capture, shift and update strobes, the scan-in bit, and a two-bit mode. The TAP state machine and the instruction decoder are not part of this block.

In SAMPLE/PRELOAD mode the pins pass through untouched. A capture takes a snapshot of every pin value for readout. An update moves the shifted pattern into the output latches, which preloads them ahead of EXTEST. In EXTEST mode the output latches drive the pads for as long as the mode is held, and a capture collects the input pins as test responses. In any other mode the chain is not selected and all strobes are ignored. The output latches have no reset, so an EXTEST that is not preceded by a preload drives undefined values.

Top module: `bsr_chain`

## Requirements
- R1: A synchronous active-high `rst` on a rising `tck` clears every shift stage, so `scan_out` reads 0. The output update latches are not cleared and keep their contents.
- R2: In every mode except EXTEST (`mode` = 2'b10), `pad_out` equals `core_out` combinationally.
- R3: `core_in` equals `pad_in` in every mode.
- R4: In SAMPLE/PRELOAD (`mode` = 2'b01), a rising `tck` with `capture_dr` high loads each input cell with its `pad_in` bit and each output cell with its `core_out` bit.
- R5: In EXTEST, a rising `tck` with `capture_dr` high loads each input cell with its `pad_in` bit and each output cell with the value currently driven on its `pad_out` bit, which is the update latch.
- R6: Chain order: chain bit i for i < `N_IN` is input cell i, and chain bit `N_IN`+j is output cell j. `scan_out` is chain bit 0. In a selected mode, a rising `tck` with `shift_dr` high (and `capture_dr` low) moves every bit one place toward bit 0 and loads `scan_in` into bit `N_IN+N_OUT-1`.
- R7: In a selected mode, a falling `tck` with `update_dr` high copies output cell shift stage j into update latch j. The latches hold their value at all other times.
- R8: In EXTEST, `pad_out` equals the update latches throughout. Changes on `core_out` and shifting of the chain do not affect it.
- R9: With `mode` = 2'b00 or 2'b11, `capture_dr`, `shift_dr` and `update_dr` have no effect: the chain contents and the update latches are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset of the shift stages |
| mode | input | 2 | 00 off, 01 SAMPLE/PRELOAD, 10 EXTEST, 11 off |
| capture_dr | input | 1 | Capture strobe, taken on the rising edge |
| shift_dr | input | 1 | Shift strobe, taken on the rising edge |
| update_dr | input | 1 | Update strobe, taken on the falling edge |
| scan_in | input | 1 | Serial data into the far end of the chain |
| scan_out | output | 1 | Serial data out of chain bit 0 |
| pad_in | input | N_IN | Values arriving from the input pads |
| core_in | output | N_IN | Input values passed on to the core |
| core_out | input | N_OUT | Output values from the core |
| pad_out | output | N_OUT | Values driven to the output pads |

## Verification
The pin paths `pad_out` and `core_in` are combinational. They are checked one nanosecond after an input change, with no clock edge in between. A capture or a shift takes effect at the first rising `tck` after the strobe is driven. For that reason the bench reads `scan_out` one nanosecond after each rising edge, before it drives the next `scan_in` bit, so each read shows the bit that the next edge will shift away. An update takes effect at the falling edge inside the cycle where `update_dr` is high, so the pads are checked after the following rising edge.

// File: rtl/bsr_pkg.sv
`timescale 1ns/1ps
package bsr_pkg;
  typedef enum logic [1:0] {
    BSR_OFF    = 2'b00,
    BSR_SAMPLE = 2'b01,
    BSR_EXTEST = 2'b10,
    BSR_RSVD   = 2'b11
  } bsr_mode_e;

  function automatic logic bsr_selected(input logic [1:0] m);
    return (m == BSR_SAMPLE) || (m == BSR_EXTEST);
  endfunction
endpackage

// File: rtl/bsr_in_cell.sv
`timescale 1ns/1ps
module bsr_in_cell (
  input  logic clk,
  input  logic rst,
  input  logic cap_en,
  input  logic shf_en,
  input  logic sin,
  input  logic pad_i,
  output logic core_o,
  output logic sq
);
  // Input pins always reach the core; the cell only observes them.
  assign core_o = pad_i;

  always_ff @(posedge clk) begin
    if (rst)         sq <= 1'b0;
    else if (cap_en) sq <= pad_i;
    else if (shf_en) sq <= sin;
  end
endmodule

// File: rtl/bsr_out_cell.sv
`timescale 1ns/1ps
module bsr_out_cell (
  input  logic clk,
  input  logic rst,
  input  logic cap_en,
  input  logic shf_en,
  input  logic upd_en,
  input  logic drive_lat,
  input  logic sin,
  input  logic core_i,
  output logic pad_o,
  output logic sq
);
  logic lat;

  // Update latch: loaded on the falling edge and never reset.
  always_ff @(negedge clk) begin
    if (upd_en) lat <= sq;
  end

  assign pad_o = drive_lat ? lat : core_i;

  // The capture takes whatever is on the pad path: core value or latch.
  always_ff @(posedge clk) begin
    if (rst)         sq <= 1'b0;
    else if (cap_en) sq <= pad_o;
    else if (shf_en) sq <= sin;
  end
endmodule

// File: rtl/bsr_chain.sv
`timescale 1ns/1ps
module bsr_chain #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input  logic             tck,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic [N_IN-1:0]  pad_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] pad_out
);
  import bsr_pkg::*;

  localparam int LEN = N_IN + N_OUT;

  logic           sel;
  logic           extest;
  logic           cap_en;
  logic           shf_en;
  logic           upd_en;
  logic [LEN-1:0] chain;
  logic [LEN-1:0] nxt;

  assign sel    = bsr_selected(mode);
  assign extest = (mode == BSR_EXTEST);
  assign cap_en = sel & capture_dr;
  assign shf_en = sel & shift_dr;
  assign upd_en = sel & update_dr;

  // Shift toward bit 0; scan_in enters the top cell.
  assign nxt      = {scan_in, chain[LEN-1:1]};
  assign scan_out = chain[0];

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    bsr_in_cell u_cell (
      .clk    (tck),
      .rst    (rst),
      .cap_en (cap_en),
      .shf_en (shf_en),
      .sin    (nxt[i]),
      .pad_i  (pad_in[i]),
      .core_o (core_in[i]),
      .sq     (chain[i])
    );
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    bsr_out_cell u_cell (
      .clk       (tck),
      .rst       (rst),
      .cap_en    (cap_en),
      .shf_en    (shf_en),
      .upd_en    (upd_en),
      .drive_lat (extest),
      .sin       (nxt[N_IN+j]),
      .core_i    (core_out[j]),
      .pad_o     (pad_out[j]),
      .sq        (chain[N_IN+j])
    );
  end
endmodule

// File: rtl/bsr_chain_chk.sv
`timescale 1ns/1ps
module bsr_chain_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input logic                   tck,
  input logic                   rst,
  input logic [1:0]             mode,
  input logic                   capture_dr,
  input logic                   shift_dr,
  input logic                   update_dr,
  input logic                   scan_in,
  input logic [N_IN-1:0]        pad_in,
  input logic [N_IN-1:0]        core_in,
  input logic [N_OUT-1:0]       core_out,
  input logic [N_OUT-1:0]       pad_out,
  input logic [N_IN+N_OUT-1:0]  chain
);
  localparam int LEN = N_IN + N_OUT;

  logic sel;
  logic ext;
  assign sel = (mode == 2'b01) || (mode == 2'b10);
  assign ext = (mode == 2'b10);

  AST_CORE_SEES_PADS: assert property (@(posedge tck) disable iff (rst)
    core_in == pad_in); // R3

  AST_PADS_FOLLOW_CORE: assert property (@(posedge tck) disable iff (rst)
    !ext |-> pad_out == core_out); // R2

  AST_CAPTURE_INPUTS: assert property (@(posedge tck) disable iff (rst)
    sel && capture_dr |=> chain[N_IN-1:0] == $past(pad_in)); // R4

  AST_EXTEST_CAPTURE_PADS: assert property (@(posedge tck) disable iff (rst)
    ext && capture_dr |=> chain[LEN-1:N_IN] == $past(pad_out)); // R5

  AST_SHIFT_STEP: assert property (@(posedge tck) disable iff (rst)
    sel && !capture_dr && shift_dr |=> chain == {$past(scan_in), $past(chain[LEN-1:1])}); // R6

  AST_OFF_HOLDS_CHAIN: assert property (@(posedge tck) disable iff (rst)
    !sel |=> $stable(chain)); // R9

  AST_EXTEST_PADS_HOLD: assert property (@(posedge tck) disable iff (rst)
    ext && $past(mode) == 2'b10 && !update_dr |-> $stable(pad_out)); // R8
endmodule

bind bsr_chain bsr_chain_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .tck        (tck),
  .rst        (rst),
  .mode       (mode),
  .capture_dr (capture_dr),
  .shift_dr   (shift_dr),
  .update_dr  (update_dr),
  .scan_in    (scan_in),
  .pad_in     (pad_in),
  .core_in    (core_in),
  .core_out   (core_out),
  .pad_out    (pad_out),
  .chain      (chain)
);

// File: tb/tb_bsr_chain.sv
`timescale 1ns/1ps
module tb_bsr_chain;
  localparam int NI  = 4;
  localparam int NO  = 4;
  localparam int L   = NI + NO;
  localparam int NV  = 8;
  localparam logic [1:0] M_EXT = 2'b10;

  // {mode[17:16], pad_in[15:12], core_out[11:8], scan data[7:0]}
  localparam logic [17:0] VEC [NV] = '{
    {2'b01, 4'hA, 4'h5, 8'h3C},
    {2'b10, 4'h6, 4'h9, 8'hA5},
    {2'b10, 4'hF, 4'h0, 8'h0F},
    {2'b00, 4'h3, 4'hC, 8'hFF},
    {2'b11, 4'h9, 4'h7, 8'h81},
    {2'b10, 4'h2, 4'hE, 8'h5A},
    {2'b01, 4'h8, 4'hB, 8'hC3},
    {2'b10, 4'h1, 4'h4, 8'h96}
  };

  logic          tck = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode = 2'b00;
  logic          capture_dr = 1'b0;
  logic          shift_dr = 1'b0;
  logic          update_dr = 1'b0;
  logic          scan_in = 1'b0;
  logic          scan_out;
  logic [NI-1:0] pad_in = '0;
  logic [NI-1:0] core_in;
  logic [NO-1:0] core_out = '0;
  logic [NO-1:0] pad_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference model kept from the requirements.
  logic [L-1:0]  m_ch = '0;
  logic [NO-1:0] m_lat = '0;

  always #2 tck = ~tck;

  bsr_chain #(.N_IN(NI), .N_OUT(NO)) dut (
    .tck(tck), .rst(rst), .mode(mode), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .scan_in(scan_in),
    .scan_out(scan_out), .pad_in(pad_in), .core_in(core_in),
    .core_out(core_out), .pad_out(pad_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit is_sel(input logic [1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  function automatic logic [NO-1:0] exp_pads(input logic [1:0] m);
    return (m == M_EXT) ? m_lat : core_out;
  endfunction

  // Capture, L shifts, update; returns the bits seen on scan_out.
  task automatic scan(input logic [L-1:0] d, output logic [L-1:0] got);
    capture_dr = 1'b1;
    @(posedge tck); #1;
    capture_dr = 1'b0;
    for (int i = 0; i < L; i++) begin
      got[i] = scan_out;
      if (i == L/2 && mode == M_EXT)
        chk(pad_out === m_lat, "R8 pads held during shift", 32'(pad_out), 32'(m_lat));
      scan_in  = d[i];
      shift_dr = 1'b1;
      @(posedge tck); #1;
    end
    shift_dr  = 1'b0;
    update_dr = 1'b1;
    @(posedge tck); #1;
    update_dr = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [L-1:0] got;
    logic [L-1:0] exp;
    // Reset
    repeat (3) @(posedge tck);
    #1 rst = 1'b0;
    chk(scan_out === 1'b0, "R1 scan_out after reset", 32'(scan_out), 0);
    #1;
    chk(pad_out === core_out, "R2 pads follow core while off", 32'(pad_out), 32'(core_out));

    // R1/R6: shift ones into a cleared chain; the first L bits out are zero.
    mode = 2'b01;
    for (int i = 0; i < L; i++) begin
      got[i]   = scan_out;
      scan_in  = 1'b1;
      shift_dr = 1'b1;
      @(posedge tck); #1;
    end
    shift_dr = 1'b0;
    chk(got === '0, "R1 R6 cleared chain shifts out zeros", 32'(got), 0);
    chk(scan_out === 1'b1, "R6 scan_in reaches scan_out after L shifts", 32'(scan_out), 1);
    m_ch = '1;

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [1:0]    vm;
      logic [NO-1:0] cap_o;
      vm       = VEC[v][17:16];
      mode     = vm;
      pad_in   = VEC[v][15:12];
      core_out = VEC[v][11:8];
      #1;
      chk(core_in === pad_in, "R3 core_in equals pad_in", 32'(core_in), 32'(pad_in));
      chk(pad_out === exp_pads(vm), (vm == M_EXT) ? "R8 pads from latches" : "R2 pads from core",
          32'(pad_out), 32'(exp_pads(vm)));
      if (is_sel(vm)) begin
        cap_o = (vm == M_EXT) ? m_lat : core_out;
        exp   = {cap_o, pad_in};
      end else begin
        exp = {L{m_ch[0]}};
      end
      scan(VEC[v][L-1:0], got);
      chk(got === exp, (vm == M_EXT) ? "R5 R6 extest capture" :
                       (vm == 2'b01) ? "R4 R6 sample capture" : "R9 off mode holds chain",
          32'(got), 32'(exp));
      if (is_sel(vm)) begin
        m_ch  = VEC[v][L-1:0];
        m_lat = m_ch[L-1:NI];
      end
      chk(pad_out === exp_pads(vm), "R7 pads after update", 32'(pad_out), 32'(exp_pads(vm)));
      core_out = ~core_out;
      #1;
      chk(pad_out === exp_pads(vm), (vm == M_EXT) ? "R8 core change ignored" : "R2 core change seen",
          32'(pad_out), 32'(exp_pads(vm)));
      // After off-mode strobes, latches must still be the old ones (R9).
      if (!is_sel(vm)) begin
        mode = M_EXT;
        #1;
        chk(pad_out === m_lat, "R9 latches untouched by off-mode update", 32'(pad_out), 32'(m_lat));
        mode = vm;
      end
    end

    // R1: reset in EXTEST clears the chain but not the latches.
    mode = M_EXT;
    #1 rst = 1'b1;
    @(posedge tck); #1;
    rst = 1'b0;
    chk(scan_out === 1'b0, "R1 chain cleared by reset", 32'(scan_out), 0);
    chk(pad_out === m_lat, "R1 latches survive reset", 32'(pad_out), 32'(m_lat));
    mode = 2'b00;
    @(posedge tck); #1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule